// File: doc/BRIEF.md
# Flyback Capacitor Charger Controller

This block sequences the power switch of a flyback converter that charges a high-voltage storage capacitor. It receives asynchronous comparator flags (supply above its undervoltage threshold, primary peak current reached, flux reset or minimum switch voltage seen, output at its target) and a charge-enable pin. It drives the switch gate command, an active-low completion flag and an enable for the gate-drive bias pump.

A charge cycle starts only on a fresh rising edge of the enable pin while the supply is valid. A fixed start delay follows. The controller then alternates on-phases and off-phases. An on-phase ends at the current limit or at an on-time ceiling. An off-phase ends at the flux-reset detect or at an off-time ceiling, whichever comes first. At low output voltage the detect does not arrive, so the ceiling sets a slow soft-start cadence. When the output trips, switching stops and the completion flag is pulled low. Lowering the enable pin returns the block to standby. Every timing limit is a count of clock cycles derived from a clock-frequency parameter.

Top module: `flyback_charge_ctrl`

## Requirements
- R1: A charge cycle starts only on a low-to-high change of `charge_a` while `uv_ok_a` is high. If `charge_a` is already high when the supply becomes valid, no cycle starts until `charge_a` has gone low and high again.
- R2: Every asynchronous input passes through two flops. For an input change driven between clock edges, the outputs react on the third rising edge that follows. `gate_on` first rises START_CYC+3 edges after the qualifying `charge_a` rise, where START_CYC = CLK_HZ/1e6 × START_US.
- R3: Once `ilim_a` is seen during an on-phase, `gate_on` falls.
- R4: An on-phase lasts at most ON_CYC cycles. The switch is forced off after that many cycles if the current limit has not arrived.
- R5: During an off-phase, `flux_rst_a` starts the next on-phase at once.
- R6: Without a flux-reset detect, the off-phase ends after exactly OFF_CYC cycles and the next on-phase begins.
- R7: When `trip_a` is seen while charging, switching stops (`gate_on` low) and `done_n` goes low. `done_n` stays low after `trip_a` is removed, for as long as `charge_a` stays high.
- R8: `done_n` is high while charging and whenever the synchronized `charge_a` is low. After `charge_a` falls, `done_n` is released two edges later.
- R9: Lowering `charge_a` ends the cycle and enters standby. A later rise of `charge_a` starts a new cycle.
- R10: `bias_en` follows the synchronized `charge_a` level, two edges behind the pin.
- R11: A drop of `uv_ok_a` at any time forces `gate_on` low, returns the block to idle, and requires a new `charge_a` rise.
- R12: While `rst_n` is low, `gate_on` is low, `done_n` is high and `bias_en` is low. `gate_on` is high only during an on-phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| uv_ok_a | input | 1 | Supply above undervoltage threshold (async) |
| charge_a | input | 1 | Charge enable pin (async) |
| ilim_a | input | 1 | Primary peak current reached (async) |
| flux_rst_a | input | 1 | Flux reset / minimum switch voltage detected (async) |
| trip_a | input | 1 | Output at target voltage (async) |
| gate_on | output | 1 | Power switch gate command |
| done_n | output | 1 | Charge complete, active low |
| bias_en | output | 1 | Gate-drive bias pump enable |

## Verification
The switching loop is driven in three ways, and each one exposes a different off-phase exit:
- A current-limit pulse followed by a flux-reset pulse separates the detect-driven exit from the timed one.
- Holding every flag quiet lets both ceilings run out. The bench samples one cycle before and exactly at the off-time boundary, so a one-cycle error in the counter shows up.
- Enable and supply sequences check start qualification: an enable that was already high when the supply became valid, a supply loss in the start delay and in an on-phase, and a restart after standby.

An output trip followed by release of the enable shows that the completion flag latches and then clears.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DELAY = 3'd1,
    ST_ON    = 3'd2,
    ST_OFF   = 3'd3,
    ST_DONE  = 3'd4
  } fcc_state_e;
endpackage

// File: rtl/fcc_sync.sv
module fcc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_a,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d_a;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fcc_timer.sv
module fcc_timer #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [CW-1:0] last,
  output logic          expired
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // High in the final cycle of the window
  assign expired = en && (cnt_q == last);
endmodule

// File: rtl/fcc_fsm.sv
module fcc_fsm
  import fcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       uv_ok,
  input  logic       chg,
  input  logic       chg_rise,
  input  logic       ilim,
  input  logic       flux_rst,
  input  logic       trip,
  input  logic       tmr_exp,
  output fcc_state_e state,
  output logic       tmr_clr,
  output logic       tmr_en
);
  fcc_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:  if (chg_rise && uv_ok) state_d = ST_DELAY;
      ST_DELAY: begin
        if (!uv_ok || !chg) state_d = ST_IDLE;
        else if (tmr_exp)   state_d = ST_ON;
      end
      ST_ON: begin
        if (!uv_ok || !chg)       state_d = ST_IDLE;
        else if (trip)            state_d = ST_DONE;
        else if (ilim || tmr_exp) state_d = ST_OFF;
      end
      ST_OFF: begin
        if (!uv_ok || !chg)           state_d = ST_IDLE;
        else if (trip)                state_d = ST_DONE;
        else if (flux_rst || tmr_exp) state_d = ST_ON;
      end
      ST_DONE:  if (!uv_ok || !chg) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  assign tmr_clr = (state_d != state);
  assign tmr_en  = (state == ST_DELAY) || (state == ST_ON) || (state == ST_OFF);
endmodule

// File: rtl/flyback_charge_ctrl.sv
module flyback_charge_ctrl
  import fcc_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int START_US = 20,
  parameter int ON_US    = 13,
  parameter int OFF_US   = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_ok_a,
  input  logic charge_a,
  input  logic ilim_a,
  input  logic flux_rst_a,
  input  logic trip_a,
  output logic gate_on,
  output logic done_n,
  output logic bias_en
);
  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int START_CYC  = CYC_PER_US * START_US;
  localparam int ON_CYC     = CYC_PER_US * ON_US;
  localparam int OFF_CYC    = CYC_PER_US * OFF_US;
  localparam int MAX_CYC    = (START_CYC > ON_CYC) ?
                              ((START_CYC > OFF_CYC) ? START_CYC : OFF_CYC) :
                              ((ON_CYC > OFF_CYC) ? ON_CYC : OFF_CYC);
  localparam int CW         = $clog2(MAX_CYC + 1);
  localparam int NSYNC      = 5;

  logic       rst_meta, rst_core_n;
  logic [NSYNC-1:0] raw_a, raw_s;
  logic       uv_s, charge_s, ilim_s, flux_s, trip_s;
  logic       charge_q;
  logic       chg_rise;
  fcc_state_e state;
  logic       tmr_clr, tmr_en, tmr_exp;
  logic [CW-1:0] tmr_last;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  assign raw_a = {trip_a, flux_rst_a, ilim_a, charge_a, uv_ok_a};

  fcc_sync #(.W(NSYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_a   (raw_a),
    .q     (raw_s)
  );

  assign {trip_s, flux_s, ilim_s, charge_s, uv_s} = raw_s;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) charge_q <= 1'b0;
    else             charge_q <= charge_s;
  end

  assign chg_rise = charge_s && !charge_q;

  always_comb begin
    unique case (state)
      ST_DELAY: tmr_last = CW'(START_CYC - 1);
      ST_ON:    tmr_last = CW'(ON_CYC - 1);
      default:  tmr_last = CW'(OFF_CYC - 1);
    endcase
  end

  fcc_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .clr     (tmr_clr),
    .en      (tmr_en),
    .last    (tmr_last),
    .expired (tmr_exp)
  );

  fcc_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .uv_ok    (uv_s),
    .chg      (charge_s),
    .chg_rise (chg_rise),
    .ilim     (ilim_s),
    .flux_rst (flux_s),
    .trip     (trip_s),
    .tmr_exp  (tmr_exp),
    .state    (state),
    .tmr_clr  (tmr_clr),
    .tmr_en   (tmr_en)
  );

  assign gate_on = (state == ST_ON);
  assign done_n  = !((state == ST_DONE) && charge_s);
  assign bias_en = charge_s;
endmodule

// File: rtl/fcc_checker.sv
module fcc_checker #(
  parameter int CLK_HZ = 50_000_000,
  parameter int ON_US  = 13
) (
  input logic clk,
  input logic rst_n,
  input logic gate_on,
  input logic done_n,
  input logic bias_en,
  input logic uv_s,
  input logic ilim_s,
  input logic trip_s
);
  localparam int ON_CYC = (CLK_HZ / 1_000_000) * ON_US;

  int on_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       on_run <= 0;
    else if (gate_on) on_run <= on_run + 1;
    else              on_run <= 0;
  end

  // R4
  on_time_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_run <= ON_CYC);

  // R3
  ilim_cuts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on && ilim_s) |=> !gate_on);

  // R11
  uv_loss_gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !uv_s |=> !gate_on);

  // R7
  done_blocks_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_n |-> !gate_on);

  // R7
  done_after_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_n) |-> $past(trip_s));

  // R8
  idle_done_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bias_en |-> done_n);

  // R10
  gate_needs_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on |-> $past(bias_en));
endmodule

bind flyback_charge_ctrl fcc_checker #(.CLK_HZ(CLK_HZ), .ON_US(ON_US)) u_fcc_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .gate_on (gate_on),
  .done_n  (done_n),
  .bias_en (bias_en),
  .uv_s    (uv_s),
  .ilim_s  (ilim_s),
  .trip_s  (trip_s)
);

// File: tb/flyback_charge_ctrl_bench.sv
module flyback_charge_ctrl_bench;
  localparam int CLK_HZ = 50_000_000;
  localparam int START  = 1000;
  localparam int ONC    = 650;
  localparam int OFFC   = 650;

  logic clk, rst_n;
  logic uv_ok_a, charge_a, ilim_a, flux_rst_a, trip_a;
  logic gate_on, done_n, bias_en;
  int   errors = 0;
  int   checks = 0;
  logic finished = 1'b0;

  flyback_charge_ctrl #(.CLK_HZ(CLK_HZ)) u_flyback_charge_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .uv_ok_a    (uv_ok_a),
    .charge_a   (charge_a),
    .ilim_a     (ilim_a),
    .flux_rst_a (flux_rst_a),
    .trip_a     (trip_a),
    .gate_on    (gate_on),
    .done_n     (done_n),
    .bias_en    (bias_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic        uv;
    logic        chg;
    logic        ilim;
    logic        flux;
    logic        trip;
    logic [15:0] wait_n;
    logic        e_gate;
    logic        e_done;
    logic        e_bias;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 16'd4,          1'b0,1'b1,1'b0, 8'd8},  // R8 idle
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 16'd4,          1'b0,1'b1,1'b1, 8'd10}, // R10 delay
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 16'(START-1),   1'b1,1'b1,1'b1, 8'd2},  // R2 start
    '{1'b1,1'b1,1'b1,1'b0,1'b0, 16'd3,          1'b0,1'b1,1'b1, 8'd3},  // R3 ilim
    '{1'b1,1'b1,1'b0,1'b1,1'b0, 16'd3,          1'b1,1'b1,1'b1, 8'd5},  // R5 flux
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 16'd3,          1'b1,1'b1,1'b1, 8'd5},  // R5 hold
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 16'(ONC),       1'b0,1'b1,1'b1, 8'd4},  // R4 on cap
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 16'(OFFC-4),    1'b0,1'b1,1'b1, 8'd6},  // R6 before
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 16'd1,          1'b1,1'b1,1'b1, 8'd6},  // R6 at edge
    '{1'b1,1'b1,1'b0,1'b0,1'b1, 16'd3,          1'b0,1'b0,1'b1, 8'd7},  // R7 trip
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 16'd3,          1'b0,1'b0,1'b1, 8'd7},  // R7 latched
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 16'd2,          1'b0,1'b1,1'b0, 8'd8},  // R8 release
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 16'd3,          1'b0,1'b1,1'b1, 8'd9},  // R9 restart
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 16'd3,          1'b0,1'b1,1'b1, 8'd11}, // R11 uv drop
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 16'(START+10),  1'b0,1'b1,1'b1, 8'd1},  // R1 stale high
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 16'd3,          1'b0,1'b1,1'b0, 8'd9},  // R9 standby
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 16'(START+3),   1'b1,1'b1,1'b1, 8'd1},  // R1 fresh rise
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 16'd3,          1'b0,1'b1,1'b1, 8'd11}, // R11 in on
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 16'(START+10),  1'b0,1'b1,1'b1, 8'd11}  // R11 needs rise
  };

  task automatic check(input int req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_outs(input int req, input logic eg, input logic ed, input logic eb);
    check(req, "gate_on", gate_on, eg);
    check(req, "done_n",  done_n,  ed);
    check(req, "bias_en", bias_en, eb);
  endtask

  initial begin
    rst_n = 1'b0;
    uv_ok_a = 1'b0; charge_a = 1'b1; ilim_a = 1'b0; flux_rst_a = 1'b0; trip_a = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state, charge pin already high
    check_outs(12, 1'b0, 1'b1, 1'b0);
    rst_n = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      uv_ok_a    = VECS[i].uv;
      charge_a   = VECS[i].chg;
      ilim_a     = VECS[i].ilim;
      flux_rst_a = VECS[i].flux;
      trip_a     = VECS[i].trip;
      repeat (int'(VECS[i].wait_n)) @(posedge clk);
      @(negedge clk);
      check_outs(int'(VECS[i].req), VECS[i].e_gate, VECS[i].e_done, VECS[i].e_bias);
    end

    // R2: exact start latency counted edge by edge
    charge_a = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    charge_a = 1'b1;
    begin
      int n;
      n = 0;
      do begin
        @(posedge clk); n++;
        @(negedge clk);
      end while (!gate_on && n < START + 20);
      checks++;
      if (n != START + 3) begin
        errors++;
        $display("FAIL R2 start latency: actual=%0d expected=%0d", n, START + 3);
      end
    end

    // R12: asynchronous reset during an on-phase
    #3 rst_n = 1'b0;
    #1 check_outs(12, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule